// File: doc/BRIEF.md
# Mailbox and Doorbell Messaging Unit

This block lets a host and a local processor signal each other through a small set of memory-mapped registers. Each direction has its own message registers and its own doorbell register. Inbound resources carry traffic toward the local processor, and outbound resources carry traffic toward the host. Each message register holds a 32-bit word. Storing a word there records an interrupt cause. Doorbell bits work as software interrupts: a producer sets bits and a consumer clears them.

Each direction has a status register and a mask register. Each direction also drives one level-sensitive interrupt line, which is high while any recorded cause is unmasked. All registers sit inside a 4 KB window, and a base register inside that window can move the window.

Access is through a single-beat register bus. A request lasts one cycle and carries a burst-length field. The response comes one cycle later. Reads of this block can have side effects, so the block never carries out a multi-word access. It answers such an access with an error and changes nothing.

Top module: `msg_unit`

## Requirements
- R1: A write to a message register (inbound at offsets 0x000+4*i, outbound at 0x040+4*i, i < MSG_N) stores the 32-bit value, and a read returns it. The write also sets status bit i of that direction, and the bit is visible in the same cycle as the write response.
- R2: Each doorbell has a set offset and a clear offset: inbound set 0x080 and clear 0x084, outbound set 0x088 and clear 0x08C. A write to the set offset sets every bit that is 1 in the data. A write to the clear offset clears every bit that is 1 in the data. A read of either offset returns the doorbell value.
- R3: Status bit MSG_N of each direction reads 1 while any bit of that direction's doorbell is set. Writing that status bit has no effect.
- R4: Message status bits, inbound at 0x090 and outbound at 0x098, are write-1-to-clear. Writing 0 to a status bit leaves it unchanged.
- R5: Each interrupt output equals the OR of (status AND NOT mask) for its direction. The masks are at 0x094 for inbound and 0x09C for outbound, with bit positions matching status. A mask bit hides a cause but does not stop the status bit from being recorded.
- R6: Inbound resources affect only the inbound status register and the `irq_in` output. Outbound resources affect only the outbound status register and the `irq_out` output.
- R7: A request inside the window whose burst length is not 1 gets a response with `rsp_err`=1 and `rsp_rdata`=0. It leaves every register and status bit unchanged.
- R8: A request whose address bits [31:12] differ from the window base gets no response and changes nothing.
- R9: Inside the window, an unused or misaligned offset, or a message index of MSG_N or more, reads as zero. Writes to it are ignored, and the response has `rsp_err`=0.
- R10: The base register at offset 0x0A0 holds window address bits [31:12] and reads back with bits [11:0] zero. It resets to BASE_RST, which is 0x1000_0000 by default. A write to it moves the window for every later request.
- R11: After reset, all message, doorbell, status and mask registers are zero, both interrupt outputs are low and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_beats | input | 4 | Burst length in words; only 1 is carried out |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Burst rejected |
| rsp_rdata | output | 32 | Read data; zero for writes and errors |
| irq_in | output | 1 | Inbound interrupt, level |
| irq_out | output | 1 | Outbound interrupt, level |

## Verification
The assertions assume that at most one request arrives per cycle. Under that assumption, a message write and a status or mask write to the same direction never fall in the same cycle, and neither do a doorbell set and a doorbell clear. The stimulus respects this by driving each request for exactly one cycle and then idling until the response has been sampled. The assertions also assume that `req_beats` is stable whenever `req_valid` is high. The bench sends error cases only as complete, isolated requests.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int BEATS_W   = 4;
    localparam int WIN_BITS  = 12;
    localparam int BASE_W    = ADDR_W - WIN_BITS;
    localparam int MSG_N_DEF = 2;
    localparam int DB_W_DEF  = 32;

    localparam logic [WIN_BITS-1:0] OFF_IN_DB_SET  = 12'h080;
    localparam logic [WIN_BITS-1:0] OFF_IN_DB_CLR  = 12'h084;
    localparam logic [WIN_BITS-1:0] OFF_OUT_DB_SET = 12'h088;
    localparam logic [WIN_BITS-1:0] OFF_OUT_DB_CLR = 12'h08C;
    localparam logic [WIN_BITS-1:0] OFF_IN_ST      = 12'h090;
    localparam logic [WIN_BITS-1:0] OFF_IN_MSK     = 12'h094;
    localparam logic [WIN_BITS-1:0] OFF_OUT_ST     = 12'h098;
    localparam logic [WIN_BITS-1:0] OFF_OUT_MSK    = 12'h09C;
    localparam logic [WIN_BITS-1:0] OFF_BASE       = 12'h0A0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_IN_MSG, SEL_OUT_MSG,
        SEL_IN_DB_SET, SEL_IN_DB_CLR, SEL_OUT_DB_SET, SEL_OUT_DB_CLR,
        SEL_IN_ST, SEL_IN_MSK, SEL_OUT_ST, SEL_OUT_MSK, SEL_BASE
    } sel_e;

    typedef struct packed {
        logic       claim;
        logic       burst;
        sel_e       sel;
        logic [3:0] idx;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic hits_window(input logic [ADDR_W-1:0] addr,
                                         input logic [BASE_W-1:0] base_hi);
        return addr[ADDR_W-1:WIN_BITS] == base_hi;
    endfunction
endpackage

// File: rtl/msgu_decode.sv
module msgu_decode
    import msgu_pkg::*;
#(
    parameter int MSG_N = MSG_N_DEF
) (
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BEATS_W-1:0] req_beats,
    input  logic [BASE_W-1:0]  base_hi,
    output dec_t               dec
);
    logic [WIN_BITS-1:0] off;
    logic                idx_ok;

    assign off    = req_addr[WIN_BITS-1:0];
    assign idx_ok = (int'(off[5:2]) < MSG_N) && (off[1:0] == 2'b00);

    always_comb begin
        dec       = '0;
        dec.claim = req_valid && hits_window(req_addr, base_hi);
        dec.burst = dec.claim && (req_beats != BEATS_W'(1));
        dec.idx   = off[5:2];
        if (off[WIN_BITS-1:6] == '0 && idx_ok)
            dec.sel = SEL_IN_MSG;
        else if (off[WIN_BITS-1:6] == 6'd1 && idx_ok)
            dec.sel = SEL_OUT_MSG;
        else begin
            case (off)
                OFF_IN_DB_SET:  dec.sel = SEL_IN_DB_SET;
                OFF_IN_DB_CLR:  dec.sel = SEL_IN_DB_CLR;
                OFF_OUT_DB_SET: dec.sel = SEL_OUT_DB_SET;
                OFF_OUT_DB_CLR: dec.sel = SEL_OUT_DB_CLR;
                OFF_IN_ST:      dec.sel = SEL_IN_ST;
                OFF_IN_MSK:     dec.sel = SEL_IN_MSK;
                OFF_OUT_ST:     dec.sel = SEL_OUT_ST;
                OFF_OUT_MSK:    dec.sel = SEL_OUT_MSK;
                OFF_BASE:       dec.sel = SEL_BASE;
                default:        dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msgu_doorbell.sv
module msgu_doorbell #(
    parameter int DB_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [DB_W-1:0] wdata,
    output logic [DB_W-1:0] db_q,
    output logic            pend
);
    always_ff @(posedge clk) begin
        if (rst)
            db_q <= '0;
        else if (set_we)
            db_q <= db_q | wdata;
        else if (clr_we)
            db_q <= db_q & ~wdata;
    end

    assign pend = |db_q;

    // R2
    db_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((db_q & $past(wdata)) == $past(wdata)));

    // R2
    db_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((db_q & $past(wdata)) == '0));
endmodule

// File: rtl/msgu_irq_bank.sv
module msgu_irq_bank #(
    parameter int MSG_N = 2,
    localparam int ST_W = MSG_N + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MSG_N-1:0] msg_set,
    input  logic             st_we,
    input  logic             msk_we,
    input  logic [ST_W-1:0]  wdata,
    input  logic             db_pend,
    output logic [ST_W-1:0]  status,
    output logic [ST_W-1:0]  mask,
    output logic             irq
);
    logic [MSG_N-1:0] st_msg_q;
    logic [MSG_N-1:0] clr_bits;

    assign clr_bits = st_we ? wdata[MSG_N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_msg_q <= '0;
            mask     <= '0;
        end else begin
            st_msg_q <= (st_msg_q & ~clr_bits) | msg_set;
            if (msk_we)
                mask <= wdata;
        end
    end

    assign status = {db_pend, st_msg_q};
    assign irq    = |(status & ~mask);

    // R1
    msg_status_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|msg_set) |=> ((st_msg_q & $past(msg_set)) == $past(msg_set)));

    // R5
    mask_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
        (msk_we && !st_we && msg_set == '0) |=> $stable(st_msg_q));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (st_we && msg_set == '0) |=> ((st_msg_q & $past(wdata[MSG_N-1:0])) == '0));
endmodule

// File: rtl/msg_unit.sv
module msg_unit
    import msgu_pkg::*;
#(
    parameter int               MSG_N    = MSG_N_DEF,
    parameter int               DB_W     = DB_W_DEF,
    parameter logic [ADDR_W-1:0] BASE_RST = 32'h1000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BEATS_W-1:0] req_beats,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               irq_in,
    output logic               irq_out
);
    localparam int ST_W = MSG_N + 1;

    dec_t              dec;
    logic [BASE_W-1:0] base_hi;
    logic              wr_ok;
    logic [DATA_W-1:0] in_msg  [MSG_N];
    logic [DATA_W-1:0] out_msg [MSG_N];
    logic [MSG_N-1:0]  in_set, out_set;
    logic [DB_W-1:0]   in_db, out_db;
    logic              in_pend, out_pend;
    logic [ST_W-1:0]   in_st, in_msk, out_st, out_msk;
    logic [DATA_W-1:0] rd_mux;
    rsp_t              rsp_q;

    msgu_decode #(.MSG_N(MSG_N)) u_dec (
        .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
        .base_hi(base_hi), .dec(dec)
    );

    assign wr_ok = dec.claim && !dec.burst && req_write;

    for (genvar i = 0; i < MSG_N; i++) begin : g_msg
        assign in_set[i]  = wr_ok && dec.sel == SEL_IN_MSG  && int'(dec.idx) == i;
        assign out_set[i] = wr_ok && dec.sel == SEL_OUT_MSG && int'(dec.idx) == i;
        always_ff @(posedge clk) begin
            if (rst) begin
                in_msg[i]  <= '0;
                out_msg[i] <= '0;
            end else begin
                if (in_set[i])  in_msg[i]  <= req_wdata;
                if (out_set[i]) out_msg[i] <= req_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            base_hi <= BASE_RST[ADDR_W-1:WIN_BITS];
        else if (wr_ok && dec.sel == SEL_BASE)
            base_hi <= req_wdata[ADDR_W-1:WIN_BITS];
    end

    msgu_doorbell #(.DB_W(DB_W)) u_in_db (
        .clk(clk), .rst(rst),
        .set_we(wr_ok && dec.sel == SEL_IN_DB_SET),
        .clr_we(wr_ok && dec.sel == SEL_IN_DB_CLR),
        .wdata(req_wdata[DB_W-1:0]), .db_q(in_db), .pend(in_pend)
    );

    msgu_doorbell #(.DB_W(DB_W)) u_out_db (
        .clk(clk), .rst(rst),
        .set_we(wr_ok && dec.sel == SEL_OUT_DB_SET),
        .clr_we(wr_ok && dec.sel == SEL_OUT_DB_CLR),
        .wdata(req_wdata[DB_W-1:0]), .db_q(out_db), .pend(out_pend)
    );

    msgu_irq_bank #(.MSG_N(MSG_N)) u_in_irq (
        .clk(clk), .rst(rst), .msg_set(in_set),
        .st_we(wr_ok && dec.sel == SEL_IN_ST),
        .msk_we(wr_ok && dec.sel == SEL_IN_MSK),
        .wdata(req_wdata[ST_W-1:0]), .db_pend(in_pend),
        .status(in_st), .mask(in_msk), .irq(irq_in)
    );

    msgu_irq_bank #(.MSG_N(MSG_N)) u_out_irq (
        .clk(clk), .rst(rst), .msg_set(out_set),
        .st_we(wr_ok && dec.sel == SEL_OUT_ST),
        .msk_we(wr_ok && dec.sel == SEL_OUT_MSK),
        .wdata(req_wdata[ST_W-1:0]), .db_pend(out_pend),
        .status(out_st), .mask(out_msk), .irq(irq_out)
    );

    always_comb begin
        rd_mux = '0;
        case (dec.sel)
            SEL_IN_MSG:                     rd_mux = in_msg[dec.idx[$clog2(MSG_N+1)-1:0] < MSG_N ? int'(dec.idx) : 0];
            SEL_OUT_MSG:                    rd_mux = out_msg[dec.idx[$clog2(MSG_N+1)-1:0] < MSG_N ? int'(dec.idx) : 0];
            SEL_IN_DB_SET, SEL_IN_DB_CLR:   rd_mux[DB_W-1:0] = in_db;
            SEL_OUT_DB_SET, SEL_OUT_DB_CLR: rd_mux[DB_W-1:0] = out_db;
            SEL_IN_ST:                      rd_mux[ST_W-1:0] = in_st;
            SEL_IN_MSK:                     rd_mux[ST_W-1:0] = in_msk;
            SEL_OUT_ST:                     rd_mux[ST_W-1:0] = out_st;
            SEL_OUT_MSK:                    rd_mux[ST_W-1:0] = out_msk;
            SEL_BASE:                       rd_mux[ADDR_W-1:WIN_BITS] = base_hi;
            default:                        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= dec.claim;
            rsp_q.err   <= dec.burst;
            rsp_q.rdata <= (dec.claim && !dec.burst && !req_write) ? rd_mux : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R8
    unclaimed_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hits_window(req_addr, base_hi)) |=> !rsp_valid);

    // R7
    burst_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> ($stable(in_st) && $stable(out_st) && $stable(in_db)
                     && $stable(out_db) && $stable(base_hi)));

    // R7
    burst_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: tb/test_msg_unit.sv
module test_msg_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_beats;
    logic        rsp_valid, rsp_err, irq_in, irq_out;
    logic [31:0] rsp_rdata;
    int          n_run = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    msg_unit i_msg_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_beats(req_beats),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  beats;
        logic        ev;
        logic        ee;
        logic [31:0] rd;
        logic        ii;
        logic        io;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h1000_0000, 32'hCAFE_F00D, 4'd1, 1'b1, 1'b0, 32'h0,         1'b1, 1'b0, 4'd1},  // R1
        '{1'b0, 32'h1000_0000, 32'h0,         4'd1, 1'b1, 1'b0, 32'hCAFE_F00D, 1'b1, 1'b0, 4'd1},  // R1
        '{1'b0, 32'h1000_0090, 32'h0,         4'd1, 1'b1, 1'b0, 32'h1,         1'b1, 1'b0, 4'd1},  // R1
        '{1'b1, 32'h1000_0090, 32'h1,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 32'h1000_0090, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 32'h1000_0088, 32'h0000_00A0, 4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b1, 4'd2},  // R2
        '{1'b0, 32'h1000_0098, 32'h0,         4'd1, 1'b1, 1'b0, 32'h4,         1'b0, 1'b1, 4'd3},  // R3
        '{1'b1, 32'h1000_009C, 32'h4,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd5},  // R5
        '{1'b0, 32'h1000_008C, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0000_00A0, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 32'h1000_008C, 32'h0000_0020, 4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 32'h1000_0088, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0000_0080, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 32'h1000_0098, 32'h4,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 32'h1000_0098, 32'h0,         4'd1, 1'b1, 1'b0, 32'h4,         1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 32'h1000_008C, 32'h0000_0080, 4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 32'h1000_009C, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd5},  // R5
        '{1'b1, 32'h1000_0004, 32'h0000_1234, 4'd4, 1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 32'h1000_0004, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 32'h1000_0090, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd7},  // R7
        '{1'b1, 32'h1000_00B0, 32'hFFFF_FFFF, 4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd9},  // R9
        '{1'b0, 32'h1000_00B0, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd9},  // R9
        '{1'b0, 32'h1000_0008, 32'h0,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 32'h1000_0044, 32'h0000_0055, 4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b1, 4'd6},  // R6
        '{1'b0, 32'h1000_0098, 32'h0,         4'd1, 1'b1, 1'b0, 32'h2,         1'b0, 1'b1, 4'd6},  // R6
        '{1'b1, 32'h1000_0094, 32'h7,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b1, 4'd5},  // R5
        '{1'b1, 32'h1000_0000, 32'h1,         4'd1, 1'b1, 1'b0, 32'h0,         1'b0, 1'b1, 4'd5},  // R5
        '{1'b0, 32'h1000_0090, 32'h0,         4'd1, 1'b1, 1'b0, 32'h1,         1'b0, 1'b1, 4'd5}   // R5
    };

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_beats = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_beats = 4'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 irq_in", {31'b0, irq_in}, 32'h0);
        check("R11 irq_out", {31'b0, irq_out}, 32'h0);
        check("R11 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        access(1'b0, 32'h1000_0098, 0, 4'd1);
        check("R11 out status", rsp_rdata, 32'h0);
        access(1'b0, 32'h1000_0040, 0, 4'd1);
        check("R11 out msg0", rsp_rdata, 32'h0);
        // R10 base reset value
        access(1'b0, 32'h1000_00A0, 0, 4'd1);
        check("R10 base reset", rsp_rdata, 32'h1000_0000);

        for (int k = 0; k < NV; k++) begin
            logic ok;
            access(VEC[k].wr, VEC[k].addr, VEC[k].wdata, VEC[k].beats);
            ok = (rsp_valid === VEC[k].ev) && (irq_in === VEC[k].ii) && (irq_out === VEC[k].io);
            if (VEC[k].ev)
                ok = ok && (rsp_err === VEC[k].ee) && (VEC[k].wr || rsp_rdata === VEC[k].rd);
            n_run++;
            if (!ok) begin
                n_fail++;
                $display("FAIL R%0d row %0d actual v=%b e=%b d=%h ii=%b io=%b expected v=%b e=%b d=%h ii=%b io=%b",
                         VEC[k].req, k, rsp_valid, rsp_err, rsp_rdata, irq_in, irq_out,
                         VEC[k].ev, VEC[k].ee, VEC[k].rd, VEC[k].ii, VEC[k].io);
            end
        end

        // R7 burst read of zero beats returns error and zero data
        access(1'b0, 32'h1000_0000, 0, 4'd0);
        check("R7 err flag", {31'b0, rsp_err}, 32'h1);
        check("R7 err data", rsp_rdata, 32'h0);
        // R8 outside window: no response, no change
        access(1'b1, 32'h2000_0004, 32'hDEAD_BEEF, 4'd1);
        check("R8 no rsp", {31'b0, rsp_valid}, 32'h0);
        access(1'b0, 32'h1000_0004, 0, 4'd1);
        check("R8 msg1 untouched", rsp_rdata, 32'h0);
        // R10 relocate window
        access(1'b1, 32'h1000_00A0, 32'h3000_0ABC, 4'd1);
        access(1'b0, 32'h3000_00A0, 0, 4'd1);
        check("R10 new base", rsp_rdata, 32'h3000_0000);
        access(1'b0, 32'h1000_0000, 0, 4'd1);
        check("R10 old window dead", {31'b0, rsp_valid}, 32'h0);
        access(1'b1, 32'h3000_0004, 32'h0BAD_CAFE, 4'd1);
        access(1'b0, 32'h3000_0004, 0, 4'd1);
        check("R10 msg at new base", rsp_rdata, 32'h0BAD_CAFE);
        // R3 doorbell status bit is read-only; R6 inbound doorbell feeds inbound only
        access(1'b1, 32'h3000_0094, 32'h0, 4'd1);
        access(1'b1, 32'h3000_0090, 32'h7, 4'd1);
        access(1'b1, 32'h3000_0080, 32'h8000_0000, 4'd1);
        check("R6 irq_in from doorbell", {31'b0, irq_in}, 32'h1);
        access(1'b1, 32'h3000_0090, 32'h4, 4'd1);
        access(1'b0, 32'h3000_0090, 0, 4'd1);
        check("R3 db status stays", rsp_rdata, 32'h4);
        access(1'b1, 32'h3000_0084, 32'h8000_0000, 4'd1);
        check("R3 irq_in drops", {31'b0, irq_in}, 32'h0);
        // R4 writing zero leaves status
        access(1'b1, 32'h3000_0000, 32'h5, 4'd1);
        access(1'b1, 32'h3000_0090, 32'h0, 4'd1);
        access(1'b0, 32'h3000_0090, 0, 4'd1);
        check("R4 zero write keeps", rsp_rdata, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule